// File: doc/BRIEF.md
# Decode-Stage Hazard Stall and Flush Controller

This block decides, every cycle, whether a five-stage in-order pipeline may advance, must hold its front end, or must squash the instruction just fetched. Branches and jumps in this pipeline are resolved in the decode stage. The controller looks at the source register fields of the instruction in decode, the decode-stage branch and jump flags, the destination and flags of the instruction in execute, the destination and load flag of the instruction in the memory stage, and the branch comparison result. From these it drives the program-counter write enable, the fetch/decode register write enable, a bubble select that replaces the decoded control fields entering execute with zeros, and a fetch flush that turns the fetched instruction into a no-op.

Three hazards are recognised. The first is a load in execute whose destination is read by the decode instruction. The second is a branch in decode whose operand is still being computed by the instruction in execute. The third is a branch in decode whose operand comes from a load that has reached the memory stage. Any of these freezes the front end for one cycle and injects a bubble. A branch that depends on a load therefore waits two cycles: one while the load is in execute and one while it is in memory. A jump, or a branch found taken, flushes the fetched instruction, but only in a cycle with no stall, because the comparison result is not valid while an operand is outstanding.

The decision is made by a combinational classifier that produces one named state per cycle. An output decoder turns that state into the four controls. The states, in priority order, are `HZ_LOAD_USE`, `HZ_BR_EX`, `HZ_BR_MEM`, `HZ_REDIRECT` and `HZ_RUN`. The classifier moves to the first state whose condition holds. `HZ_RUN` is the fall-through state when nothing applies.

Top module: `hz_detect`

## Requirements
- R1: When `ex_memread` is 1 and `ex_dst` is nonzero and equals `id_rs` or `id_rt`, the block stalls, whatever the branch and jump flags are.
- R2: In a stall cycle `pc_we` and `ifid_we` are both 0. In every other cycle both are 1.
- R3: In a stall cycle `idex_bubble` is 1. In every other cycle it is 0.
- R4: When `id_branch` is 1 and `ex_regwrite` is 1 and `ex_dst` is nonzero and equals `id_rs` or `id_rt`, the block stalls.
- R5: When `id_branch` is 1 and `mem_memread` is 1 and `mem_dst` is nonzero and equals `id_rs` or `id_rt`, the block stalls. This is the second stall cycle of a branch that depends on a load.
- R6: With no stall, `if_flush` is 1 exactly when `id_jump` is 1, or when `id_branch` and `br_taken` are both 1.
- R7: In a stall cycle `if_flush` is 0, even when a jump or a taken branch is present.
- R8: A destination field of 0 never matches a source, so it never causes a stall.
- R9: With no stall and no redirect, the outputs are `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `if_flush`=0. `br_taken` has no effect when `id_branch` is 0.
- R10: When `id_branch` is 0, an execute-stage writer that is not a load, and any memory-stage load, cause no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs | input | REG_AW | First source register field of the decode instruction |
| id_rt | input | REG_AW | Second source register field of the decode instruction |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_jump | input | 1 | Decode instruction is an unconditional jump |
| br_taken | input | 1 | Decode-stage branch comparison result |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_AW | Destination register of the execute-stage instruction |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| idex_bubble | output | 1 | Select all-zero control fields into the decode/execute register |
| if_flush | output | 1 | Zero the instruction field of the fetch/decode register |

## Verification
The bench uses a 2-bit register field and sweeps every combination of the four register fields and the six flags. Some patterns have the destination equal to only the first source, only the second source, or both; comparing these separates the two source comparators. Other patterns have a matching destination of zero, which tells a correct zero exclusion apart from a raw equality test. Patterns with a matching writer in execute that is not a load, and with a load in memory, are each tried with the branch flag set and cleared; this shows whether the branch-only stalls are gated correctly. Jumps and taken branches are combined with every stall source, which checks both the flush condition and the rule that a stall suppresses the flush.

// File: rtl/hz_pkg.sv
package hz_pkg;
    // Per-cycle decision of the hazard controller, listed by priority.
    typedef enum logic [2:0] {
        HZ_RUN      = 3'd0,
        HZ_LOAD_USE = 3'd1,
        HZ_BR_EX    = 3'd2,
        HZ_BR_MEM   = 3'd3,
        HZ_REDIRECT = 3'd4
    } hz_state_e;

    localparam int unsigned HZ_N_SRC = 2;
endpackage

// File: rtl/hz_reg_match.sv
module hz_reg_match #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned N_SRC  = 2
) (
    input  logic                    en,
    input  logic [REG_AW-1:0]       dst,
    input  logic [N_SRC*REG_AW-1:0] srcs,
    output logic                    hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [N_SRC-1:0] eq;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
            assign eq[g] = (srcs[g*REG_AW +: REG_AW] == dst);
        end
    endgenerate

    assign hit = en && (dst != ZERO_REG) && (|eq);
endmodule

// File: rtl/hz_classify.sv
module hz_classify
    import hz_pkg::*;
(
    input  logic      hit_load_use,
    input  logic      hit_br_ex,
    input  logic      hit_br_mem,
    input  logic      id_branch,
    input  logic      id_jump,
    input  logic      br_taken,
    output hz_state_e state
);
    always_comb begin
        if (hit_load_use) begin
            state = HZ_LOAD_USE;
        end else if (hit_br_ex) begin
            state = HZ_BR_EX;
        end else if (hit_br_mem) begin
            state = HZ_BR_MEM;
        end else if (id_jump || (id_branch && br_taken)) begin
            state = HZ_REDIRECT;
        end else begin
            state = HZ_RUN;
        end
    end
endmodule

// File: rtl/hz_out_decode.sv
module hz_out_decode
    import hz_pkg::*;
(
    input  hz_state_e state,
    output logic      pc_we,
    output logic      ifid_we,
    output logic      idex_bubble,
    output logic      if_flush
);
    always_comb begin
        pc_we       = 1'b1;
        ifid_we     = 1'b1;
        idex_bubble = 1'b0;
        if_flush    = 1'b0;
        unique case (state)
            HZ_RUN: begin
            end
            HZ_LOAD_USE, HZ_BR_EX, HZ_BR_MEM: begin
                pc_we       = 1'b0;
                ifid_we     = 1'b0;
                idex_bubble = 1'b1;
            end
            HZ_REDIRECT: begin
                if_flush = 1'b1;
            end
            default: begin
                pc_we       = 1'b0;
                ifid_we     = 1'b0;
                idex_bubble = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_branch,
    input  logic              id_jump,
    input  logic              br_taken,
    input  logic              ex_memread,
    input  logic              ex_regwrite,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              mem_memread,
    input  logic [REG_AW-1:0] mem_dst,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble,
    output logic              if_flush
);
    localparam int unsigned SRC_W = HZ_N_SRC * REG_AW;

    logic [SRC_W-1:0] id_srcs;
    logic             hit_load_use;
    logic             hit_br_ex;
    logic             hit_br_mem;
    hz_state_e        state;

    assign id_srcs = {id_rt, id_rs};

    hz_reg_match #(.REG_AW(REG_AW), .N_SRC(HZ_N_SRC)) u_m_load (
        .en   (ex_memread),
        .dst  (ex_dst),
        .srcs (id_srcs),
        .hit  (hit_load_use)
    );

    hz_reg_match #(.REG_AW(REG_AW), .N_SRC(HZ_N_SRC)) u_m_brex (
        .en   (id_branch && ex_regwrite),
        .dst  (ex_dst),
        .srcs (id_srcs),
        .hit  (hit_br_ex)
    );

    hz_reg_match #(.REG_AW(REG_AW), .N_SRC(HZ_N_SRC)) u_m_brmem (
        .en   (id_branch && mem_memread),
        .dst  (mem_dst),
        .srcs (id_srcs),
        .hit  (hit_br_mem)
    );

    hz_classify u_cls (
        .hit_load_use (hit_load_use),
        .hit_br_ex    (hit_br_ex),
        .hit_br_mem   (hit_br_mem),
        .id_branch    (id_branch),
        .id_jump      (id_jump),
        .br_taken     (br_taken),
        .state        (state)
    );

    hz_out_decode u_dec (
        .state       (state),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .idex_bubble (idex_bubble),
        .if_flush    (if_flush)
    );
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int unsigned REG_AW = 5
) (
    input logic [REG_AW-1:0] id_rs,
    input logic [REG_AW-1:0] id_rt,
    input logic              id_branch,
    input logic              id_jump,
    input logic              br_taken,
    input logic              ex_memread,
    input logic [REG_AW-1:0] ex_dst,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_bubble,
    input logic              if_flush
);
    always_comb begin
        a_r2_front_end_frozen_together: assert (pc_we == ifid_we)
            else $error("R2: pc_we and ifid_we disagree");
        a_r3_bubble_iff_frozen: assert (idex_bubble == !pc_we)
            else $error("R3: bubble does not track stall");
        a_r6_flush_needs_redirect: assert (!if_flush || id_jump || (id_branch && br_taken))
            else $error("R6: flush without jump or taken branch");
        a_r7_no_flush_while_stalled: assert (!(if_flush && !pc_we))
            else $error("R7: flush during stall");
        a_r1_load_use_stalls: assert (!(ex_memread && ex_dst != '0 &&
                                        (ex_dst == id_rs || ex_dst == id_rt)) || !pc_we)
            else $error("R1: load-use hazard did not stall");
    end
endmodule

bind hz_detect hz_checker #(.REG_AW(REG_AW)) u_hz_chk (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_branch   (id_branch),
    .id_jump     (id_jump),
    .br_taken    (br_taken),
    .ex_memread  (ex_memread),
    .ex_dst      (ex_dst),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble),
    .if_flush    (if_flush)
);

// File: tb/tb_hz_detect.sv
module tb_hz_detect;
    localparam int unsigned AW     = 2;
    localparam int unsigned N_VEC  = 1 << (4 * AW + 6);
    localparam int unsigned WD_LIM = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] id_rs, id_rt, ex_dst, mem_dst;
    logic id_branch, id_jump, br_taken, ex_memread, ex_regwrite, mem_memread;
    logic pc_we, ifid_we, idex_bubble, if_flush;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    hz_detect #(.REG_AW(AW)) dut (
        .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch), .id_jump(id_jump),
        .br_taken(br_taken), .ex_memread(ex_memread), .ex_regwrite(ex_regwrite),
        .ex_dst(ex_dst), .mem_memread(mem_memread), .mem_dst(mem_dst),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .if_flush(if_flush)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b rs=%0d rt=%0d exd=%0d memd=%0d br=%0b j=%0b tk=%0b exmr=%0b exrw=%0b memmr=%0b",
                     tag, what, act, exp, id_rs, id_rt, ex_dst, mem_dst, id_branch, id_jump,
                     br_taken, ex_memread, ex_regwrite, mem_memread);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIM && !done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        {id_rs, id_rt, ex_dst, mem_dst} = '0;
        {id_branch, id_jump, br_taken, ex_memread, ex_regwrite, mem_memread} = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state after reset: R9
        chk("R9", "pc_we", pc_we, 1'b1);
        chk("R9", "ifid_we", ifid_we, 1'b1);
        chk("R9", "idex_bubble", idex_bubble, 1'b0);
        chk("R9", "if_flush", if_flush, 1'b0);

        for (int v = 0; v < N_VEC; v++) begin
            logic [4*AW+5:0] vec;
            bit raw_lu, raw_be, raw_bm, lu, be, bm, stall, redir, exw_match;
            string tag, ftag;
            vec = (4*AW+6)'(v);
            @(posedge clk);
            #2;
            {id_rs, id_rt, ex_dst, mem_dst} = vec[4*AW+5:6];
            {id_branch, id_jump, br_taken, ex_memread, ex_regwrite, mem_memread} = vec[5:0];
            @(negedge clk);

            exw_match = (ex_dst == id_rs) || (ex_dst == id_rt);
            raw_lu = ex_memread && exw_match;
            raw_be = id_branch && ex_regwrite && exw_match;
            raw_bm = id_branch && mem_memread && ((mem_dst == id_rs) || (mem_dst == id_rt));
            lu = raw_lu && (ex_dst != 0);
            be = raw_be && (ex_dst != 0);
            bm = raw_bm && (mem_dst != 0);
            stall = lu || be || bm;
            redir = id_jump || (id_branch && br_taken);

            if (lu)                                tag = "R1";
            else if (be)                           tag = "R4";
            else if (bm)                           tag = "R5";
            else if (raw_lu || raw_be || raw_bm)   tag = "R8";
            else if (!id_branch && ((ex_regwrite && exw_match) || mem_memread)) tag = "R10";
            else                                   tag = "R9";

            if (stall && redir)  ftag = "R7";
            else if (redir)      ftag = "R6";
            else                 ftag = tag;

            chk({"R2 ", tag}, "pc_we", pc_we, !stall);
            chk({"R2 ", tag}, "ifid_we", ifid_we, !stall);
            chk({"R3 ", tag}, "idex_bubble", idex_bubble, stall);
            chk(ftag, "if_flush", if_flush, redir && !stall);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule